// File: doc/BRIEF.md
# Bus Error Latch and Double-Fault Detector

This block sits beside a simple processor core and decides what a bus error does. At the end of each bus cycle it looks at the bus-error line. An error that arrives while halt is asserted is not counted. An error that counts does not interrupt the instruction that is running. It sets a pending latch, and one exception request is raised when the instruction boundary is reached. The block then follows the exception sequence: the request, the core's signal that exception processing has begun, and the first instruction of the handler. That first handler instruction clears the latch.

Some bus errors cannot be recovered, and these are double bus faults. One is a second error after exception processing has begun and before the handler's first instruction. One is any error after reset and before the first instruction following reset. One is an error while a bus-error stack frame is being reloaded by a return-from-exception. A double bus fault moves the block into a halted state that only reset leaves.

The block also controls data capture on the bus. A cycle that ends in a bus error captures no read data. If that cycle was an instruction fetch, the instruction register is loaded with all ones. All inputs are synchronous to `clk`, reset is synchronous and active high, and every output is registered, so each output reflects the edge that has just passed.

Top module: `buserr_guard`

## Requirements
- R1: A bus error is recognised only in a cycle where `cycleEnd`, `berrIn` and a low `haltIn` are all present. `berrIn` outside `cycleEnd`, or with `haltIn` high, sets nothing and raises no fault. A cycle that ends with `haltIn` high captures its data normally.
- R2: `excReq` is raised only by the edge on which `instrDone` is high and an error is pending. An error recognised on that same edge counts. No request is raised in the middle of an instruction.
- R3: Any number of recognised errors within one instruction produce exactly one `excReq`, and that pulse lasts one cycle.
- R4: `handlerFirst`, while exception processing is active, clears the pending latch. A later `instrDone` with no new error raises no request.
- R5: Exception processing begins when `excActive` follows a request. From then until `handlerFirst`, a recognised error sets `dblHalt`. An error between the request and `excActive` is absorbed into the request that is already pending.
- R6: After reset and before `resetFirst`, any recognised error sets `dblHalt`.
- R7: A recognised error with `rteLoad` high sets `dblHalt`. `rteLoad` with no error has no effect.
- R8: `capEn` pulses, and `dataOut` takes `rdData`, after every cycle end without a recognised error. After an errored cycle, `capEn` stays low and `dataOut` is unchanged. `irOut` takes `rdData` on a clean fetch (`prefetch` high) and 8'hFF on an errored fetch.
- R9: `dblHalt` stays high until reset and blocks all further requests. Reset clears every output to zero.
- R10: When a request and a double fault fall on the same edge, the double fault wins: `dblHalt` rises and `excReq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycleEnd | input | 1 | Last cycle of a bus transfer |
| berrIn | input | 1 | Bus error line |
| haltIn | input | 1 | Halt line; when high, a bus error is not counted |
| prefetch | input | 1 | The ending bus cycle is an instruction fetch |
| rdData | input | DATA_W | Read data of the ending bus cycle |
| instrDone | input | 1 | Current instruction completes this cycle |
| handlerFirst | input | 1 | First instruction of the bus-error handler executes |
| resetFirst | input | 1 | First instruction after reset executes |
| excActive | input | 1 | Core has begun exception processing |
| rteLoad | input | 1 | Bus-error stack frame is being reloaded by a return-from-exception |
| excReq | output | 1 | One-cycle bus-error exception request |
| dblHalt | output | 1 | Double bus fault; core halted |
| capEn | output | 1 | Read data was captured on the last edge |
| dataOut | output | DATA_W | Captured read data |
| irOut | output | DATA_W | Instruction register value |

## Verification
The bench sends two errors into one instruction and checks that a single one-cycle request follows. A design that counted errors would issue two requests, and one that raised the exception at once would assert it in mid-instruction. It drives `berrIn` with `haltIn` high and also `berrIn` outside a cycle end, which catch a design that samples the line too early or ignores halt. It checks that a request is cleared by the first handler instruction. An error arriving after the request but before `excActive` must be absorbed, and one arriving after `excActive` must be fatal. Each of the three fault windows is hit, and so is a request that falls on the same edge as a double fault. A wrong priority would show a request pulse alongside `dblHalt`. The bench also checks the forced all-ones instruction value and confirms that `dataOut` holds its value across errored cycles.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_RUN,
    ST_REQ,
    ST_EXC,
    ST_HALT
  } bfd_state_e;

  typedef struct packed {
    logic capData;
    logic loadIr;
    logic forceIr;
    logic setPend;
    logic clrPend;
  } bfd_strobe_t;

endpackage

// File: rtl/bfd_ctrl.sv
module bfd_ctrl
  import bfd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cycleEnd,
  input  logic        berrIn,
  input  logic        haltIn,
  input  logic        prefetch,
  input  logic        instrDone,
  input  logic        handlerFirst,
  input  logic        resetFirst,
  input  logic        excActive,
  input  logic        rteLoad,
  input  logic        pendQ,
  output bfd_strobe_t strb,
  output logic        excReq,
  output logic        dblHalt
);

  bfd_state_e stQ, stNext;
  logic       reqQ, reqNext;
  logic       busErr;

  // an error counts only at the end of a bus cycle with halt negated
  assign busErr = cycleEnd & berrIn & ~haltIn;

  always_comb begin
    stNext  = stQ;
    reqNext = 1'b0;
    unique case (stQ)
      ST_BOOT: begin
        if (busErr)          stNext = ST_HALT;
        else if (resetFirst) stNext = ST_RUN;
      end
      ST_RUN: begin
        if (busErr && rteLoad) begin
          stNext = ST_HALT;
        end else if (instrDone && (pendQ || busErr)) begin
          stNext  = ST_REQ;
          reqNext = 1'b1;
        end
      end
      ST_REQ: begin
        if (excActive) stNext = ST_EXC;
      end
      ST_EXC: begin
        if (busErr)            stNext = ST_HALT;
        else if (handlerFirst) stNext = ST_RUN;
      end
      ST_HALT: stNext = ST_HALT;
      default: stNext = ST_HALT;
    endcase
  end

  always_comb begin
    strb.capData = cycleEnd & ~busErr;
    strb.loadIr  = cycleEnd & prefetch & ~busErr;
    strb.forceIr = busErr & prefetch;
    strb.setPend = busErr & (stQ == ST_RUN);
    strb.clrPend = (stQ == ST_EXC) & handlerFirst & ~busErr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stQ  <= ST_BOOT;
      reqQ <= 1'b0;
    end else begin
      stQ  <= stNext;
      reqQ <= reqNext;
    end
  end

  assign excReq  = reqQ;
  assign dblHalt = (stQ == ST_HALT);

  p_req_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    excReq |-> $past(instrDone));

  p_req_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    excReq |=> !excReq);

  p_handler_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (stQ == ST_EXC && handlerFirst && !busErr) |=> !pendQ);

  p_exc_window_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (stQ == ST_EXC && cycleEnd && berrIn && !haltIn) |=> dblHalt);

  p_boot_fault_r6: assert property (@(posedge clk) disable iff (rst)
    (stQ == ST_BOOT && cycleEnd && berrIn && !haltIn) |=> dblHalt);

  p_rte_fault_r7: assert property (@(posedge clk) disable iff (rst)
    (stQ == ST_RUN && rteLoad && cycleEnd && berrIn && !haltIn) |=> dblHalt);

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    dblHalt |=> dblHalt);

  p_fault_over_req_r10: assert property (@(posedge clk) disable iff (rst)
    dblHalt |-> !excReq);

endmodule

// File: rtl/bfd_datapath.sv
module bfd_datapath
  import bfd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bfd_strobe_t       strb,
  input  logic [DATA_W-1:0] rdData,
  output logic              pendQ,
  output logic              capEn,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] irOut
);

  localparam logic [DATA_W-1:0] FILL_VAL = {DATA_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ   <= 1'b0;
      capEn   <= 1'b0;
      dataOut <= '0;
      irOut   <= '0;
    end else begin
      capEn <= strb.capData;
      if (strb.capData) dataOut <= rdData;
      if (strb.forceIr)     irOut <= FILL_VAL;
      else if (strb.loadIr) irOut <= rdData;
      if (strb.clrPend)      pendQ <= 1'b0;
      else if (strb.setPend) pendQ <= 1'b1;
    end
  end

  p_fetch_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(strb.forceIr && strb.loadIr));

endmodule

// File: rtl/buserr_guard.sv
module buserr_guard
  import bfd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycleEnd,
  input  logic              berrIn,
  input  logic              haltIn,
  input  logic              prefetch,
  input  logic [DATA_W-1:0] rdData,
  input  logic              instrDone,
  input  logic              handlerFirst,
  input  logic              resetFirst,
  input  logic              excActive,
  input  logic              rteLoad,
  output logic              excReq,
  output logic              dblHalt,
  output logic              capEn,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] irOut
);

  bfd_strobe_t strb;
  logic        pendQ;

  bfd_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cycleEnd     (cycleEnd),
    .berrIn       (berrIn),
    .haltIn       (haltIn),
    .prefetch     (prefetch),
    .instrDone    (instrDone),
    .handlerFirst (handlerFirst),
    .resetFirst   (resetFirst),
    .excActive    (excActive),
    .rteLoad      (rteLoad),
    .pendQ        (pendQ),
    .strb         (strb),
    .excReq       (excReq),
    .dblHalt      (dblHalt)
  );

  bfd_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .rdData  (rdData),
    .pendQ   (pendQ),
    .capEn   (capEn),
    .dataOut (dataOut),
    .irOut   (irOut)
  );

  p_no_capture_on_err_r8: assert property (@(posedge clk) disable iff (rst)
    (cycleEnd && berrIn && !haltIn) |=> !capEn);

  p_fetch_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (cycleEnd && berrIn && !haltIn && prefetch) |=> (irOut == {DATA_W{1'b1}}));

  p_halt_masks_err_r1: assert property (@(posedge clk) disable iff (rst)
    (cycleEnd && haltIn) |=> capEn);

endmodule

// File: tb/tb_buserr_guard.sv
module tb_buserr_guard;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cycleEnd, berrIn, haltIn, prefetch;
  logic [7:0] rdData;
  logic       instrDone, handlerFirst, resetFirst, excActive, rteLoad;
  logic       excReq, dblHalt, capEn;
  logic [7:0] dataOut, irOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  logic [18:0] qExp[$];
  string       qTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  buserr_guard #(.DATA_W(8)) dut (
    .clk(clk), .rst(rst), .cycleEnd(cycleEnd), .berrIn(berrIn), .haltIn(haltIn),
    .prefetch(prefetch), .rdData(rdData), .instrDone(instrDone),
    .handlerFirst(handlerFirst), .resetFirst(resetFirst), .excActive(excActive),
    .rteLoad(rteLoad), .excReq(excReq), .dblHalt(dblHalt), .capEn(capEn),
    .dataOut(dataOut), .irOut(irOut)
  );

  task automatic clearIns();
    cycleEnd = 0; berrIn = 0; haltIn = 0; prefetch = 0; rdData = 8'h00;
    instrDone = 0; handlerFirst = 0; resetFirst = 0; excActive = 0; rteLoad = 0;
  endtask

  // driver: one clock with the inputs set by the caller, then queue the expectation
  task automatic cyc(input logic eReq, input logic eHalt, input logic eCap,
                     input logic [7:0] eIr, input logic [7:0] eData, input string tg);
    @(posedge clk);
    #1;
    qExp.push_back({eReq, eHalt, eCap, eIr, eData});
    qTag.push_back(tg);
    @(negedge clk);
    clearIns();
  endtask

  task automatic doReset();
    rst = 1'b1;
    clearIns();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: compare after each edge, away from it
  always @(negedge clk) begin
    if (qExp.size() > 0) begin
      logic [18:0] e;
      string t;
      e = qExp.pop_front();
      t = qTag.pop_front();
      nChecks++;
      if ({excReq, dblHalt, capEn, irOut, dataOut} !== e) begin
        nFails++;
        $display("FAIL %s: req/halt/cap/ir/data actual %b/%b/%b/%h/%h expected %b/%b/%b/%h/%h",
                 t, excReq, dblHalt, capEn, irOut, dataOut,
                 e[18], e[17], e[16], e[15:8], e[7:0]);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    clearIns();
    doReset();
    // R9 reset state
    cyc(0, 0, 0, 8'h00, 8'h00, "R9");
    resetFirst = 1;
    cyc(0, 0, 0, 8'h00, 8'h00, "R6");
    // R8 clean data read, then clean fetch
    cycleEnd = 1; rdData = 8'h5A;
    cyc(0, 0, 1, 8'h00, 8'h5A, "R8");
    cycleEnd = 1; prefetch = 1; rdData = 8'h3C;
    cyc(0, 0, 1, 8'h3C, 8'h3C, "R8");
    // R1 halt high masks the error, data still captured
    cycleEnd = 1; berrIn = 1; haltIn = 1; rdData = 8'h11;
    cyc(0, 0, 1, 8'h3C, 8'h11, "R1");
    instrDone = 1;
    cyc(0, 0, 0, 8'h3C, 8'h11, "R1");
    // R1 berr outside a cycle end is not sampled
    berrIn = 1;
    cyc(0, 0, 0, 8'h3C, 8'h11, "R1");
    instrDone = 1;
    cyc(0, 0, 0, 8'h3C, 8'h11, "R1");
    // R2 and R8: error mid instruction, no request, no capture
    cycleEnd = 1; berrIn = 1; rdData = 8'h77;
    cyc(0, 0, 0, 8'h3C, 8'h11, "R2");
    // R8 errored fetch forces all ones
    cycleEnd = 1; berrIn = 1; prefetch = 1; rdData = 8'h99;
    cyc(0, 0, 0, 8'hFF, 8'h11, "R8");
    cyc(0, 0, 0, 8'hFF, 8'h11, "R2");
    // R3 one request for two errors, single pulse
    instrDone = 1;
    cyc(1, 0, 0, 8'hFF, 8'h11, "R3");
    cyc(0, 0, 0, 8'hFF, 8'h11, "R3");
    // R5 error before excActive is absorbed
    cycleEnd = 1; berrIn = 1;
    cyc(0, 0, 0, 8'hFF, 8'h11, "R5");
    excActive = 1;
    cyc(0, 0, 0, 8'hFF, 8'h11, "R5");
    // R4 handler clears latch
    handlerFirst = 1;
    cyc(0, 0, 0, 8'hFF, 8'h11, "R4");
    instrDone = 1;
    cyc(0, 0, 0, 8'hFF, 8'h11, "R4");
    // R2 error on the completing edge counts
    cycleEnd = 1; berrIn = 1; instrDone = 1;
    cyc(1, 0, 0, 8'hFF, 8'h11, "R2");
    excActive = 1;
    cyc(0, 0, 0, 8'hFF, 8'h11, "R5");
    // R5 second error inside the window
    cycleEnd = 1; berrIn = 1;
    cyc(0, 1, 0, 8'hFF, 8'h11, "R5");
    // R9 sticky, no request while halted
    instrDone = 1; handlerFirst = 1;
    cyc(0, 1, 0, 8'hFF, 8'h11, "R9");
    doReset();
    cyc(0, 0, 0, 8'h00, 8'h00, "R9");
    // R6 boot window: halt-high error ignored, real error fatal
    cycleEnd = 1; berrIn = 1; haltIn = 1; rdData = 8'h22;
    cyc(0, 0, 1, 8'h00, 8'h22, "R1");
    cycleEnd = 1; berrIn = 1;
    cyc(0, 1, 0, 8'h00, 8'h22, "R6");
    doReset();
    // R7 rte reload window
    resetFirst = 1;
    cyc(0, 0, 0, 8'h00, 8'h00, "R7");
    rteLoad = 1;
    cyc(0, 0, 0, 8'h00, 8'h00, "R7");
    cycleEnd = 1; berrIn = 1; rteLoad = 1;
    cyc(0, 1, 0, 8'h00, 8'h00, "R7");
    doReset();
    // R10 fault and request on the same edge
    resetFirst = 1;
    cyc(0, 0, 0, 8'h00, 8'h00, "R10");
    cycleEnd = 1; berrIn = 1;
    cyc(0, 0, 0, 8'h00, 8'h00, "R10");
    cycleEnd = 1; berrIn = 1; rteLoad = 1; instrDone = 1;
    cyc(0, 1, 0, 8'h00, 8'h00, "R10");
    cyc(0, 1, 0, 8'h00, 8'h00, "R10");
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule